// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns a set of external input lines into interrupt and event requests. Each line has its own edge detector. The detector can be armed for rising edges, falling edges or both. When a qualifying edge is seen, the line can latch a pending bit that drives a level interrupt, fire a single-cycle event pulse, or do both. Each of these actions is gated by its own mask. Software reads the pending bits and clears them through a small word-addressed register port, and it can also raise a pending bit directly.

The low lines are multiplexed from several GPIO ports. A line with index n always takes pin n of whichever port its 3-bit selector names. The remaining upper lines come from dedicated inputs. Edges are captured by toggle flops that are clocked by the line itself. A pulse shorter than a bus clock period is therefore still recorded and then carried into the bus clock domain through a synchronizer.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Register words are: 0 interrupt mask, 1 event mask, 2 rising enable, 3 falling enable, 4 software trigger, 5 pending, 6 and 7 port selects. In words 0 to 5, bit n belongs to line n. After reset every word reads 0 and `irq_o` and `evt_o` are low.
- R2: A rising edge on a line whose rising enable and interrupt mask are set sets that line's pending bit, even when the pulse is narrower than one clock period.
- R3: A falling edge on a line whose falling enable is set sets its pending bit. With both enables set, either direction sets it.
- R4: An edge whose direction is not enabled on that line changes no pending bit and produces no event.
- R5: Writing 1 to a bit of the pending word clears that bit. Bits written as 0 keep their value.
- R6: If a qualifying edge or software trigger reaches a line in the same cycle as a clear of its pending bit, the bit stays set.
- R7: Writing 1 to a bit of the software trigger word sets that line's pending bit. The trigger word always reads 0.
- R8: `irq_o[n]` is high exactly when pending bit n and interrupt mask bit n are both set. A hardware edge sets the pending bit only if the interrupt mask bit is set at that moment. A software trigger sets it regardless of the mask.
- R9: A qualifying edge on a line whose event mask is set gives a `evt_o` pulse one clock long. The event path never sets the pending bit.
- R10: Line n below 16 takes pin n of the port named in its select field. That field is bits [4*(n%8)+2 : 4*(n%8)] of word 6 + n/8. A select value of 5 or more gives a constant low line. Lines 16 to 18 take `ext_i[0..2]`.
- R11: An edge that occurs between clock edges k and k+1 shows on `irq_o` or `evt_o` after clock edge k+3 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| gpio_i | input | 80 | GPIO ports, port p pin n at bit 16*p+n |
| ext_i | input | 3 | Dedicated inputs for lines 16 to 18 |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 19 | Per-line interrupt level |
| evt_o | output | 19 | Per-line one-cycle event pulse |

## Verification
The hardest case to reach from the ports is an edge that arrives at the pending register in the very cycle in which software writes a clear to the same bit. The bench first sets the bit through the software trigger. It then places a narrow pulse just after a falling clock edge and starts the clear write so that the write strobe spans the third rising edge after the pulse. Sub-cycle pulses, both-edge lines, masked lines and out-of-range port selects are each driven while a behavioural model tracks the pending and event state on every clock.

// File: rtl/eic_pkg.sv
package eic_pkg;
   // register word map
   localparam int ADR_IMASK    = 0;
   localparam int ADR_EMASK    = 1;
   localparam int ADR_RISE     = 2;
   localparam int ADR_FALL     = 3;
   localparam int ADR_SWTRIG   = 4;
   localparam int ADR_PEND     = 5;
   localparam int ADR_SEL_BASE = 6;
   // bits reserved per port-select field inside a select word
   localparam int SEL_FIELD_W  = 4;
endpackage

// File: rtl/eic_line_src.sv
module eic_line_src #(
   parameter int NUM_LINES = 19,
   parameter int MUX_LINES = 16,
   parameter int NUM_PORTS = 5,
   parameter int PINS      = 16,
   parameter int SEL_W     = 3
) (
   input  logic [NUM_PORTS*PINS-1:0]         gpio_i,
   input  logic [NUM_LINES-MUX_LINES-1:0]    ext_i,
   input  logic [MUX_LINES-1:0][SEL_W-1:0]   sel_i,
   output logic [NUM_LINES-1:0]              line_o
);
   localparam int EXT = NUM_LINES - MUX_LINES;

   for (genvar n = 0; n < MUX_LINES; n++) begin : g_mux
      logic v;
      always_comb begin
         v = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(sel_i[n]) == p) v = gpio_i[p*PINS + n];
         end
      end
      assign line_o[n] = v;
   end

   assign line_o[MUX_LINES +: EXT] = ext_i;
endmodule

// File: rtl/eic_edge_capture.sv
module eic_edge_capture #(
   parameter int N           = 19,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] line_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] r_tgl, f_tgl;
   logic [SYNC_STAGES:0][N-1:0] r_sync, f_sync;

   // toggle flops clocked by the line: sub-cycle pulses leave a mark
   for (genvar n = 0; n < N; n++) begin : g_tgl
      logic rt, ft;
      always_ff @(posedge line_i[n] or posedge rst) begin
         if (rst) rt <= 1'b0;
         else     rt <= ~rt;
      end
      always_ff @(negedge line_i[n] or posedge rst) begin
         if (rst) ft <= 1'b0;
         else     ft <= ~ft;
      end
      assign r_tgl[n] = rt;
      assign f_tgl[n] = ft;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         r_sync <= '0;
         f_sync <= '0;
      end else begin
         r_sync[0] <= r_tgl;
         f_sync[0] <= f_tgl;
         for (int i = 1; i <= SYNC_STAGES; i++) begin
            r_sync[i] <= r_sync[i-1];
            f_sync[i] <= f_sync[i-1];
         end
      end
   end

   assign rise_o = r_sync[SYNC_STAGES-1] ^ r_sync[SYNC_STAGES];
   assign fall_o = f_sync[SYNC_STAGES-1] ^ f_sync[SYNC_STAGES];
endmodule

// File: rtl/eic_regs.sv
module eic_regs
   import eic_pkg::*;
#(
   parameter int NUM_LINES = 19,
   parameter int MUX_LINES = 16,
   parameter int SEL_W     = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [DATA_W-1:0]               wdata_i,
   input  logic [NUM_LINES-1:0]            hit_i,
   output logic [DATA_W-1:0]               rdata_o,
   output logic [NUM_LINES-1:0]            imask_o,
   output logic [NUM_LINES-1:0]            emask_o,
   output logic [NUM_LINES-1:0]            rise_en_o,
   output logic [NUM_LINES-1:0]            fall_en_o,
   output logic [NUM_LINES-1:0]            pend_o,
   output logic [MUX_LINES-1:0][SEL_W-1:0] sel_o
);
   localparam int LPW = DATA_W / SEL_FIELD_W;

   logic [NUM_LINES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q;
   logic [NUM_LINES-1:0] wbits, set_vec, clr_vec;
   logic [MUX_LINES-1:0][SEL_W-1:0] sel_q;
   logic unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign wbits   = wdata_i[NUM_LINES-1:0];
   assign set_vec = (hit_i & imask_q) |
                    ((wr_i && int'(addr_i) == ADR_SWTRIG) ? wbits : '0);
   assign clr_vec = (wr_i && int'(addr_i) == ADR_PEND) ? wbits : '0;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         imask_q <= '0;
         emask_q <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         pend_q  <= '0;
         sel_q   <= '0;
      end else begin
         if (wr_i) begin
            case (int'(addr_i))
               ADR_IMASK: imask_q <= wbits;
               ADR_EMASK: emask_q <= wbits;
               ADR_RISE:  rise_q  <= wbits;
               ADR_FALL:  fall_q  <= wbits;
               default: ;
            endcase
            for (int n = 0; n < MUX_LINES; n++) begin
               if (int'(addr_i) == ADR_SEL_BASE + n/LPW)
                  sel_q[n] <= wdata_i[(n%LPW)*SEL_FIELD_W +: SEL_W];
            end
         end
         // a set arriving with a clear wins
         pend_q <= (pend_q & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (int'(addr_i))
         ADR_IMASK: rdata_o[NUM_LINES-1:0] = imask_q;
         ADR_EMASK: rdata_o[NUM_LINES-1:0] = emask_q;
         ADR_RISE:  rdata_o[NUM_LINES-1:0] = rise_q;
         ADR_FALL:  rdata_o[NUM_LINES-1:0] = fall_q;
         ADR_PEND:  rdata_o[NUM_LINES-1:0] = pend_q;
         default: ;
      endcase
      for (int n = 0; n < MUX_LINES; n++) begin
         if (int'(addr_i) == ADR_SEL_BASE + n/LPW)
            rdata_o[(n%LPW)*SEL_FIELD_W +: SEL_W] = sel_q[n];
      end
   end

   assign imask_o   = imask_q;
   assign emask_o   = emask_q;
   assign rise_en_o = rise_q;
   assign fall_en_o = fall_q;
   assign pend_o    = pend_q;
   assign sel_o     = sel_q;

   // R5: cleared bits with no concurrent set read 0 next cycle
   p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
      (|clr_vec) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
   // R6: any set request is present next cycle, clear or not
   p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
   // R8: a pending bit never appears without a set request
   p_pend_cause_r8: assert property (@(posedge clk) disable iff (rst)
      ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import eic_pkg::*;
#(
   parameter int NUM_LINES     = 19,
   parameter int MUX_LINES     = 16,
   parameter int NUM_PORTS     = 5,
   parameter int PINS_PER_PORT = 16,
   parameter int SEL_W         = 3,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 4,
   parameter int SYNC_STAGES   = 2,
   localparam int EXT_LINES    = NUM_LINES - MUX_LINES
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpio_i,
   input  logic [EXT_LINES-1:0]              ext_i,
   input  logic                              wr_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic [DATA_W-1:0]                 rdata_o,
   output logic [NUM_LINES-1:0]              irq_o,
   output logic [NUM_LINES-1:0]              evt_o
);
   localparam int SEL_WORDS = (MUX_LINES * SEL_FIELD_W + DATA_W - 1) / DATA_W;

   if (EXT_LINES < 1 || MUX_LINES > PINS_PER_PORT || NUM_LINES > DATA_W ||
       (1 << SEL_W) < NUM_PORTS || SEL_W > SEL_FIELD_W || SYNC_STAGES < 2 ||
       ADR_SEL_BASE + SEL_WORDS > (1 << ADDR_W)) begin : g_bad_cfg
      $error("edge_irq_ctrl: inconsistent parameters");
   end

   logic [NUM_LINES-1:0] line, rise, fall, hit;
   logic [NUM_LINES-1:0] imask, emask, rise_en, fall_en, pend, evt_q;
   logic [MUX_LINES-1:0][SEL_W-1:0] sel;

   eic_line_src #(
      .NUM_LINES(NUM_LINES), .MUX_LINES(MUX_LINES), .NUM_PORTS(NUM_PORTS),
      .PINS(PINS_PER_PORT), .SEL_W(SEL_W)
   ) u_src (
      .gpio_i(gpio_i), .ext_i(ext_i), .sel_i(sel), .line_o(line)
   );

   eic_edge_capture #(.N(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst(rst), .line_i(line), .rise_o(rise), .fall_o(fall)
   );

   assign hit = (rise & rise_en) | (fall & fall_en);

   eic_regs #(
      .NUM_LINES(NUM_LINES), .MUX_LINES(MUX_LINES), .SEL_W(SEL_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .hit_i(hit), .rdata_o(rdata_o), .imask_o(imask), .emask_o(emask),
      .rise_en_o(rise_en), .fall_en_o(fall_en), .pend_o(pend), .sel_o(sel)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) evt_q <= '0;
      else     evt_q <= hit & emask;
   end

   assign evt_o = evt_q;
   assign irq_o = pend & imask;

   // R9: an event pulse only on lines whose event mask was set
   p_evt_masked_r9: assert property (@(posedge clk) disable iff (rst)
      ((evt_o & ~$past(emask)) == '0));
endmodule

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
   localparam int NL = 19;
   localparam logic [NL-1:0] ALL = '1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [79:0] gpio = '0;
   logic [2:0]  ext = '0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NL-1:0] irq, evt;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   edge_irq_ctrl i_edge_irq_ctrl (
      .clk(clk), .rst(rst), .gpio_i(gpio), .ext_i(ext), .wr_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .evt_o(evt)
   );

   // ---------------- behavioural reference model ----------------
   logic [NL-1:0] m_imask = '0, m_emask = '0, m_rise = '0, m_fall = '0;
   logic [NL-1:0] m_pend = '0, m_evt = '0;
   logic [2:0]    m_sel [16];
   logic [NL-1:0] lmod, lprev = '0;
   logic [NL-1:0] seen_r = '0, seen_f = '0;
   logic [NL-1:0] p1r = '0, p1f = '0, p2r = '0, p2f = '0;

   initial for (int i = 0; i < 16; i++) m_sel[i] = '0;

   always_comb begin
      for (int n = 0; n < 16; n++)
         lmod[n] = (m_sel[n] < 3'd5) ? gpio[int'(m_sel[n])*16 + n] : 1'b0;
      lmod[18:16] = ext;
   end

   always @(lmod) begin
      seen_r = seen_r | (lmod & ~lprev);
      seen_f = seen_f | (~lmod & lprev);
      lprev  = lmod;
   end

   always @(posedge clk) begin
      logic [NL-1:0] hitm, setm, clrm;
      if (rst) begin
         m_imask <= '0; m_emask <= '0; m_rise <= '0; m_fall <= '0;
         m_pend <= '0; m_evt <= '0;
         p1r <= '0; p1f <= '0; p2r <= '0; p2f <= '0;
         seen_r = '0; seen_f = '0;
         for (int i = 0; i < 16; i++) m_sel[i] <= '0;
      end else begin
         hitm = (p2r & m_rise) | (p2f & m_fall);
         setm = (hitm & m_imask) | ((wr && addr == 4'd4) ? wdata[NL-1:0] : '0);
         clrm = (wr && addr == 4'd5) ? wdata[NL-1:0] : '0;
         m_pend <= (m_pend & ~clrm) | setm;
         m_evt  <= hitm & m_emask;
         p2r <= p1r; p2f <= p1f;
         p1r <= seen_r; p1f <= seen_f;
         seen_r = '0; seen_f = '0;
         if (wr) begin
            case (addr)
               4'd0: m_imask <= wdata[NL-1:0];
               4'd1: m_emask <= wdata[NL-1:0];
               4'd2: m_rise  <= wdata[NL-1:0];
               4'd3: m_fall  <= wdata[NL-1:0];
               4'd6: for (int i = 0; i < 8; i++) m_sel[i]   <= wdata[4*i +: 3];
               4'd7: for (int i = 0; i < 8; i++) m_sel[8+i] <= wdata[4*i +: 3];
               default: ;
            endcase
         end
      end
   end

   // compare outputs with the model on every clock
   always @(negedge clk) begin
      if (!rst) begin
         checks += 2;
         if (irq !== (m_pend & m_imask)) begin
            fails++;
            $display("FAIL R8 irq actual=%h expected=%h", irq, m_pend & m_imask);
         end
         if (evt !== m_evt) begin
            fails++;
            $display("FAIL R9 evt actual=%h expected=%h", evt, m_evt);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wreg(input int a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = 4'(a); wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rreg(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = 4'(a);
      #1 d = rdata;
   endtask

   task automatic pulse_pin(input int idx);
      @(negedge clk);
      #1 gpio[idx] = 1'b1;
      #2 gpio[idx] = 1'b0;
   endtask

   task automatic set_pin(input int idx, input logic v);
      @(negedge clk);
      #1 gpio[idx] = v;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic run();
      logic [31:0] d;
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rreg(a, d);
         chk("R1 reset word", d, 32'h0);
      end
      chk("R1 irq after reset", 32'(irq), 32'h0);
      chk("R1 evt after reset", 32'(evt), 32'h0);

      wreg(0, 32'(ALL));
      wreg(2, 32'(ALL & ~(19'h1 << 5) & ~(19'h1 << 6)));
      wreg(3, 32'((19'h1 << 4) | (19'h1 << 6)));

      // R2 narrow rising pulse, R11 latency
      pulse_pin(3);
      @(negedge clk);
      @(negedge clk);
      chk("R11 irq before third edge", 32'(irq[3]), 32'h0);
      @(negedge clk);
      chk("R11 irq after third edge", 32'(irq[3]), 32'h1);
      rreg(5, d);
      chk("R2 sub-cycle pulse pending", d, 32'h8);

      // R7 software trigger
      wreg(4, 32'h1000);
      rreg(5, d);
      chk("R7 trigger sets pending", d, 32'h1008);
      rreg(4, d);
      chk("R7 trigger word reads 0", d, 32'h0);

      // R5 write-one-to-clear
      wreg(5, 32'h8);
      rreg(5, d);
      chk("R5 only written bit cleared", d, 32'h1000);
      wreg(5, 32'h1000);

      // R4 direction disabled
      pulse_pin(5);
      settle();
      rreg(5, d);
      chk("R4 disabled line ignored", d, 32'h0);

      // R3 falling-only line
      set_pin(6, 1'b1);
      settle();
      rreg(5, d);
      chk("R3 rise ignored on fall-only line", d, 32'h0);
      set_pin(6, 1'b0);
      settle();
      rreg(5, d);
      chk("R3 fall sets pending", d, 32'h40);
      wreg(5, 32'h40);

      // R3 both directions
      set_pin(4, 1'b1);
      settle();
      rreg(5, d);
      chk("R3 both: rise", d, 32'h10);
      wreg(5, 32'h10);
      set_pin(4, 1'b0);
      settle();
      rreg(5, d);
      chk("R3 both: fall", d, 32'h10);
      wreg(5, 32'h10);

      // R6 edge arrives with the clear
      wreg(4, 32'h80);
      pulse_pin(7);
      @(negedge clk);
      wreg(5, 32'h80);
      rreg(5, d);
      chk("R6 set beats clear", d, 32'h80);
      wreg(5, 32'h80);
      rreg(5, d);
      chk("R5 clear after collision", d, 32'h0);

      // R8 interrupt mask
      wreg(0, 32'(ALL & ~(19'h1 << 8)));
      pulse_pin(8);
      settle();
      rreg(5, d);
      chk("R8 masked edge not pending", d, 32'h0);
      wreg(4, 32'h100);
      rreg(5, d);
      chk("R8 trigger ignores mask", d, 32'h100);
      chk("R8 irq held low by mask", 32'(irq[8]), 32'h0);
      wreg(0, 32'(ALL));
      chk("R8 irq follows unmask", 32'(irq[8]), 32'h1);
      wreg(5, 32'h100);

      // R9 event pulse on a dedicated line
      wreg(1, 32'h10000);
      wreg(0, 32'(ALL & ~(19'h1 << 16)));
      @(negedge clk);
      #1 ext[0] = 1'b1;
      #2 ext[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R9 no event before third edge", 32'(evt), 32'h0);
      @(negedge clk);
      chk("R9 event pulse", 32'(evt), 32'h10000);
      @(negedge clk);
      chk("R9 event lasts one cycle", 32'(evt), 32'h0);
      rreg(5, d);
      chk("R9 event leaves pending clear", d, 32'h0);
      wreg(0, 32'(ALL));

      // R10 port selection
      wreg(6, 32'h400);
      rreg(6, d);
      chk("R10 select readback", d, 32'h400);
      pulse_pin(4*16 + 2);
      settle();
      rreg(5, d);
      chk("R10 line 2 from port 4", d, 32'h4);
      wreg(5, 32'h4);
      pulse_pin(2);
      settle();
      rreg(5, d);
      chk("R10 unselected port ignored", d, 32'h0);
      wreg(7, 32'h60);
      pulse_pin(9);
      pulse_pin(4*16 + 9);
      settle();
      rreg(5, d);
      chk("R10 out-of-range select is low", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      fork
         begin
            run();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule